// File: doc/BRIEF.md
# Two-Cycle Input Agreement Tracker

This block watches two single-bit inputs and, on every clock edge, records whether they carried the same value. It keeps a short history of that comparison in a two-bit state register. From that register alone it drives two flags. One flag is raised when the inputs matched on each of the two most recent sampled cycles. The other flag is raised when the inputs did not match on the most recent sampled cycle.

Both flags come from the state register only, so this is a Moore machine. A change on the inputs between clock edges never reaches the outputs until the next edge. The synchronous reset clears the history, and no flag is shown until real samples have been taken. The tracker is meant to sit next to a pair of redundant or mirrored signals. There it reports sustained agreement or a fresh disagreement, one cycle after the sample.

The state encoding has a fixed meaning:

| Code | Meaning |
|------|---------|
| 2'b00 | No history since reset |
| 2'b01 | The inputs differed on the last sample |
| 2'b10 | One matching sample, following reset or a mismatch |
| 2'b11 | Two or more consecutive matching samples |

Bit 1 of the code is set exactly when the last sample matched.

Top module: `eq_history_fsm`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the state becomes 2'b00, and `match2_o` and `mismatch_o` are both 0 after that edge.
- R2: If `in_a` equals `in_b` at two consecutive rising edges with `rst_n` high, `match2_o` is 1 after the second of those edges.
- R3: If `in_a` differs from `in_b` at a rising edge with `rst_n` high, `mismatch_o` is 1 and `match2_o` is 0 after that edge.
- R4: A matching sample that follows reset or a mismatching sample leaves both `match2_o` and `mismatch_o` at 0 after its edge.
- R5: `match2_o` and `mismatch_o` are never 1 in the same cycle.
- R6: The outputs depend only on the state register, so changing `in_a` or `in_b` between clock edges has no effect on `match2_o` or `mismatch_o` before the next edge.
- R7: While the inputs keep matching on every edge, `match2_o` stays 1. After a single mismatching sample, `match2_o` stays 0 until two more matching samples have been taken.
- R8: While `rst_n` is low, mismatching inputs do not raise `mismatch_o`, and matching inputs do not count toward the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_a | input | 1 | First compared input |
| in_b | input | 1 | Second compared input |
| match2_o | output | 1 | Inputs matched at both of the last two edges |
| mismatch_o | output | 1 | Inputs differed at the last edge |

## Verification
The two flags are decoded from different state codes, so they cannot both be high. The risky moment comes when a streak of matches is broken, because the agreement flag must fall on the same edge where the disagreement flag rises. The bench provokes this by ending a run of matching samples with one mismatch, and it also uses random input streams that switch often between matching and mismatching. On every sampled cycle, both flags are compared with a reference model built on a shift register of equality results, and the bench separately checks that the two flags are never high together.

// File: rtl/eq_fsm_pkg.sv
// Package: shared state encoding for the input agreement tracker.
// Assumes: bit 1 of the code means "the last sample matched". The next-state
// logic and the output decoder both rely on this.
package eq_fsm_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_EMPTY = 2'b00,   // no history since reset
        ST_DIFF  = 2'b01,   // last sample mismatched
        ST_EQ1   = 2'b10,   // one matching sample
        ST_EQ2   = 2'b11    // two or more matching samples in a row
    } hist_state_t;

endpackage

// File: rtl/eq_fsm_next.sv
// Module: eq_fsm_next
// Computes the next history state from the present state and the current
// input comparison. Purely combinational.
// Assumes: the present state is a legal enum value.
module eq_fsm_next
    import eq_fsm_pkg::*;
(
    input  hist_state_t cur_st,
    input  logic        same_i,
    output hist_state_t nxt_st
);

    // Pick the next history code from the current comparison result.
    always_comb begin
        if (!same_i) begin
            nxt_st = ST_DIFF;
        end else if (cur_st[1]) begin
            nxt_st = ST_EQ2;
        end else begin
            nxt_st = ST_EQ1;
        end
    end

endmodule

// File: rtl/eq_fsm_decode.sv
// Module: eq_fsm_decode
// Produces the two Moore flags from the state code only.
// Assumes: the flags are registered or used directly. Either is fine,
// because the inputs here are flop outputs.
module eq_fsm_decode
    import eq_fsm_pkg::*;
(
    input  hist_state_t st,
    output logic        pair_eq,
    output logic        last_diff
);

    // Decode each flag from its own state code.
    always_comb begin
        pair_eq   = (st == ST_EQ2);
        last_diff = (st == ST_DIFF);
    end

endmodule

// File: rtl/eq_history_fsm.sv
// Module: eq_history_fsm (top)
// Tracks whether in_a and in_b agreed on recent clock edges. The tracker
// holds the result in a two-bit state register. It raises match2_o after
// two matching samples in a row, and mismatch_o after one mismatching sample.
// Assumes: the inputs are synchronous to clk, and rst_n is synchronous and
// active low.
module eq_history_fsm
    import eq_fsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    output logic match2_o,
    output logic mismatch_o
);

    hist_state_t state_q;
    hist_state_t state_d;
    logic        same;

    // Compare the two inputs in the current cycle.
    always_comb begin
        same = (in_a == in_b);
    end

    eq_fsm_next u_next (
        .cur_st (state_q),
        .same_i (same),
        .nxt_st (state_d)
    );

    // Hold the history state. Reset clears it synchronously.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    eq_fsm_decode u_dec (
        .st        (state_q),
        .pair_eq   (match2_o),
        .last_diff (mismatch_o)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!match2_o && !mismatch_o)); // R1

    AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (same && state_q[1]) |=> match2_o); // R2

    AST_DIFF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !same |=> (mismatch_o && !match2_o)); // R3

    AST_FIRST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (same && !state_q[1]) |=> (!match2_o && !mismatch_o)); // R4

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(match2_o && mismatch_o)); // R5

endmodule

// File: tb/eq_history_fsm_test.sv
// Directed bench for eq_history_fsm. Each task covers one scenario and
// checks its own results against a reference model. The model keeps the
// last two equality results in a shift register.
module eq_history_fsm_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0;
    logic in_b = 1'b0;
    logic match2_o;
    logic mismatch_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference history: bit 0 is the newest sample, and vld marks taken samples.
    logic [1:0] ref_eq  = 2'b00;
    logic [1:0] ref_vld = 2'b00;

    eq_history_fsm uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_a       (in_a),
        .in_b       (in_b),
        .match2_o   (match2_o),
        .mismatch_o (mismatch_o)
    );

    always #5 clk = ~clk;

    function automatic logic exp_match2();
        return ref_vld[0] & ref_vld[1] & ref_eq[0] & ref_eq[1];
    endfunction

    function automatic logic exp_mismatch();
        return ref_vld[0] & ~ref_eq[0];
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive one sample, clock it, update the model, and sample 2 ns after the edge.
    task automatic step(input logic a, input logic b);
        in_a = a;
        in_b = b;
        @(posedge clk);
        if (!rst_n) begin
            ref_eq  = 2'b00;
            ref_vld = 2'b00;
        end else begin
            ref_eq  = {ref_eq[0], (a == b)};
            ref_vld = {ref_vld[0], 1'b1};
        end
        #2;
    endtask

    task automatic check_both(input string req);
        check(req, "match2_o", match2_o, exp_match2());
        check(req, "mismatch_o", mismatch_o, exp_mismatch());
        check("R5", "exclusive", match2_o & mismatch_o, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "match2_o after reset", match2_o, 1'b0);
        check("R1", "mismatch_o after reset", mismatch_o, 1'b0);
    endtask

    task automatic t_two_equal();
        do_reset();
        step(1'b1, 1'b1);
        check_both("R4");
        step(1'b0, 1'b0);
        check("R2", "match2_o after two matches", match2_o, 1'b1);
        check_both("R2");
    endtask

    task automatic t_streak_break();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            step(i[0], i[0]);
            check_both("R7");
        end
        check("R7", "match2_o held in streak", match2_o, 1'b1);
        step(1'b1, 1'b0);
        check("R3", "mismatch_o after break", mismatch_o, 1'b1);
        check("R3", "match2_o dropped at break", match2_o, 1'b0);
        step(1'b0, 1'b0);
        check("R4", "match2_o after one match", match2_o, 1'b0);
        check("R4", "mismatch_o after one match", mismatch_o, 1'b0);
        step(1'b1, 1'b1);
        check("R7", "match2_o restored", match2_o, 1'b1);
    endtask

    task automatic t_repeat_diff();
        do_reset();
        step(1'b0, 1'b1);
        check_both("R3");
        step(1'b1, 1'b0);
        check("R3", "mismatch_o second diff", mismatch_o, 1'b1);
    endtask

    task automatic t_mid_cycle();
        logic m2;
        logic mm;
        do_reset();
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        m2 = match2_o;
        mm = mismatch_o;
        in_a = 1'b0;
        #1;
        check("R6", "match2_o stable mid cycle", match2_o, m2);
        check("R6", "mismatch_o stable mid cycle", mismatch_o, mm);
        step(1'b0, 1'b1);
        in_b = 1'b0;
        #1;
        check("R6", "mismatch_o stable mid cycle", mismatch_o, 1'b1);
    endtask

    task automatic t_reset_override();
        do_reset();
        rst_n = 1'b0;
        step(1'b1, 1'b0);
        check("R8", "mismatch_o in reset", mismatch_o, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check("R8", "match2_o in reset", match2_o, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        check("R8", "match2_o after one post-reset match", match2_o, 1'b0);
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 400; i++) begin
            step(1'($urandom), 1'($urandom));
            check_both("R7");
        end
    endtask

    initial begin
        t_reset();
        t_two_equal();
        t_streak_break();
        t_repeat_diff();
        t_mid_cycle();
        t_reset_override();
        t_random();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule